// File: doc/BRIEF.md
# ISA I/O Slave Front-End

This block sits between a peripheral's registers and an ISA-style expansion bus. It compares each bus address against a base that software can program. When the address falls inside the device's window, the block raises the 16-bit chip-select indication and stores data from I/O write strobes into a small bank of 16-bit registers. During an I/O read it returns the selected register and can hold the bus off for a fixed number of cycles through the channel-ready line.

The interface always comes out of reset, whether hardware or software, in byte-wide mode. In that mode only the low byte of a register can be written. Wide transfers are enabled only after the high-byte-enable line has gone low and then high again. Write strobes are ignored while a memory refresh is in progress.

One interrupt request and one DMA request are each steered to one line of a group. The other lines of the group stay in high impedance. Every open-drain or three-state pin is brought out as a data bit plus an output-enable bit, so high-impedance behaviour can be seen directly.

Top module: `isa_io_slave`

## Requirements
- R1: A write is stored when the write strobe is low, the refresh input is high and the address lies in the window [base, base + 2*NUM_REGS). Register index = (address - base) >> 1.
- R2: While the refresh input is low, write strobes change no register.
- R3: An address outside the window changes no register and leaves the chip-select pin in high impedance (cs16_oe = 0). An address inside the window drives the pin low (cs16_oe = 1, cs16_o = 0).
- R4: After reset the interface is in byte-wide mode (mode16 = 0). In this mode a write updates bits 7:0 only, and bits 15:8 keep their old value.
- R5: Wide mode (mode16 = 1) is entered only when the high-byte-enable input rises after a previous fall. A software reset pulse returns the interface to byte-wide mode.
- R6: In wide mode, bits 15:8 are written only when the high-byte-enable input is low. Bits 7:0 are always written.
- R7: When the ready-disable configuration bit is clear, each I/O read that starts inside the window drives channel-ready low (chrdy_oe = 1, chrdy_o = 0) for exactly WAIT_CYC cycles.
- R8: When the ready-disable bit is set, the channel-ready pin stays in high impedance (chrdy_oe = 0).
- R9: Only the interrupt line whose index equals the interrupt select is enabled. It is active-high and carries the pending flag, which an interrupt event sets.
- R10: The pending flag is cleared by a status-queue read that reports empty. A status-queue read that reports non-empty leaves the flag set.
- R11: Only the DMA line whose index equals the DMA select is enabled, and it carries the DMA request. A select of NUM_DMA or above enables no line. dma_ack is the inverse of the active-low acknowledge input of the selected line.
- R12: During an I/O read inside the window, rd_data_oe is 1 and rd_data holds the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_addr | input | ADDR_W | Programmed I/O base |
| cfg_rdy_dis | input | 1 | Ready-disable bit (1 = channel-ready kept tri-stated) |
| cfg_irq_sel | input | IRQ_SEL_W | Index of the driven interrupt line |
| cfg_dma_sel | input | DMA_SEL_W | Index of the driven DMA line |
| soft_rst | input | 1 | Software reset pulse, returns to byte-wide mode |
| bus_addr | input | ADDR_W | Bus I/O address |
| bus_data_in | input | 16 | Bus write data |
| bus_iow_n | input | 1 | I/O write strobe, active-low |
| bus_ior_n | input | 1 | I/O read strobe, active-low |
| bus_refresh_n | input | 1 | Refresh in progress, active-low |
| bus_sbhe_n | input | 1 | High-byte enable, active-low |
| rd_data | output | 16 | Read data |
| rd_data_oe | output | 1 | Read data drive enable |
| cs16_o | output | 1 | 16-bit chip-select data (always 0) |
| cs16_oe | output | 1 | 16-bit chip-select enable |
| chrdy_o | output | 1 | Channel-ready data (always 0) |
| chrdy_oe | output | 1 | Channel-ready enable, pulls the line low |
| irq_event | input | 1 | Interrupt event pulse |
| isq_rd | input | 1 | Status-queue read strobe |
| isq_empty | input | 1 | Status-queue read returned all zeros |
| irq_o | output | NUM_IRQ | Interrupt line data |
| irq_oe | output | NUM_IRQ | Interrupt line enables |
| dma_req | input | 1 | Internal DMA request |
| dmarq_o | output | NUM_DMA | DMA request line data |
| dmarq_oe | output | NUM_DMA | DMA request line enables |
| dmack_n | input | NUM_DMA | DMA acknowledge inputs, active-low |
| dma_ack | output | 1 | Acknowledge of the selected DMA line |
| mode16 | output | 1 | Wide mode active |

## Verification
The bench builds the block with NUM_REGS = 4, WAIT_CYC = 2, NUM_IRQ = 4, NUM_DMA = 3 and ADDR_W = 10, with the base at 0x300. A window of eight bytes lets the bench probe addresses just below and just above the window. A two-cycle wait makes the exact length of the channel-ready pulse quick to count. Three DMA lines behind a two-bit select leave one select code unused, so the no-line case can be reached.

// File: rtl/isa_slv_pkg.sv
`timescale 1ns/1ps
package isa_slv_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WS_NARROW = 2'd0,
    WS_ARMED  = 2'd1,
    WS_WIDE   = 2'd2
  } width_st_e;
endpackage

// File: rtl/isa_addr_decode.sv
`timescale 1ns/1ps
module isa_addr_decode #(
  parameter int ADDR_W   = 10,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(2 * NUM_REGS);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr_i - base_i;
    hit_o  = (offset < WIN_BYTES);
    idx_o  = offset[IDX_W:1];
  end
endmodule

// File: rtl/isa_width_tracker.sv
`timescale 1ns/1ps
module isa_width_tracker
  import isa_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic sbhe_n_i,
  output logic mode16_o
);
  width_st_e st_q, st_d;
  logic      sbhe_prev_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_NARROW: if (sbhe_prev_q && !sbhe_n_i) st_d = WS_ARMED;
      WS_ARMED:  if (!sbhe_prev_q && sbhe_n_i) st_d = WS_WIDE;
      WS_WIDE:   st_d = WS_WIDE;
      default:   st_d = WS_NARROW;
    endcase
    if (soft_rst_i) st_d = WS_NARROW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= WS_NARROW;
      sbhe_prev_q <= 1'b1;
    end else begin
      st_q        <= st_d;
      sbhe_prev_q <= sbhe_n_i;
    end
  end

  assign mode16_o = (st_q == WS_WIDE);

  // R5
  wide_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode16_o) |-> ($past(sbhe_n_i) && !$past(sbhe_prev_q) && !$past(soft_rst_i)));

  // R5
  soft_rst_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !mode16_o);
endmodule

// File: rtl/isa_ready_timer.sv
`timescale 1ns/1ps
module isa_ready_timer #(
  parameter int WAIT_CYC = 4,
  localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dis_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (dis_i)                cnt_d = '0;
    else if (start_i)         cnt_d = CNT_W'(WAIT_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R7
  rdy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && !dis_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  rdy_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !busy_o);
endmodule

// File: rtl/isa_line_router.sv
`timescale 1ns/1ps
module isa_line_router #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             val_i,
  output logic [N-1:0]     line_o,
  output logic [N-1:0]     line_oe
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign line_oe[g] = (sel_i == SEL_W'(g));
    assign line_o[g]  = line_oe[g] & val_i;
  end
endmodule

// File: rtl/isa_io_slave.sv
`timescale 1ns/1ps
module isa_io_slave
  import isa_slv_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_REGS  = 8,
  parameter int WAIT_CYC  = 4,
  parameter int NUM_IRQ   = 4,
  parameter int NUM_DMA   = 3,
  localparam int IRQ_SEL_W = $clog2(NUM_IRQ),
  localparam int DMA_SEL_W = $clog2(NUM_DMA)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_base_addr,
  input  logic                 cfg_rdy_dis,
  input  logic [IRQ_SEL_W-1:0] cfg_irq_sel,
  input  logic [DMA_SEL_W-1:0] cfg_dma_sel,
  input  logic                 soft_rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [15:0]          bus_data_in,
  input  logic                 bus_iow_n,
  input  logic                 bus_ior_n,
  input  logic                 bus_refresh_n,
  input  logic                 bus_sbhe_n,
  output logic [15:0]          rd_data,
  output logic                 rd_data_oe,
  output logic                 cs16_o,
  output logic                 cs16_oe,
  output logic                 chrdy_o,
  output logic                 chrdy_oe,
  input  logic                 irq_event,
  input  logic                 isq_rd,
  input  logic                 isq_empty,
  output logic [NUM_IRQ-1:0]   irq_o,
  output logic [NUM_IRQ-1:0]   irq_oe,
  input  logic                 dma_req,
  output logic [NUM_DMA-1:0]   dmarq_o,
  output logic [NUM_DMA-1:0]   dmarq_oe,
  input  logic [NUM_DMA-1:0]   dmack_n,
  output logic                 dma_ack,
  output logic                 mode16
);
  localparam int IDX_W = $clog2(NUM_REGS);

  // bus sample stage
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic              iow_q, ior_q, ior_prev_q, refresh_q, sbhe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      data_q     <= '0;
      iow_q      <= 1'b1;
      ior_q      <= 1'b1;
      ior_prev_q <= 1'b1;
      refresh_q  <= 1'b1;
      sbhe_q     <= 1'b1;
    end else begin
      addr_q     <= bus_addr;
      data_q     <= bus_data_in;
      iow_q      <= bus_iow_n;
      ior_q      <= bus_ior_n;
      ior_prev_q <= ior_q;
      refresh_q  <= bus_refresh_n;
      sbhe_q     <= bus_sbhe_n;
    end
  end

  // address window
  logic             hit_w;
  logic [IDX_W-1:0] idx_w;

  isa_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .base_i (cfg_base_addr),
    .addr_i (addr_q),
    .hit_o  (hit_w),
    .idx_o  (idx_w)
  );

  // bus width mode
  isa_width_tracker u_width (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst),
    .sbhe_n_i   (sbhe_q),
    .mode16_o   (mode16)
  );

  // register bank
  logic [NUM_REGS-1:0][BUS_W-1:0] regs_q, regs_d;
  logic wr_en;

  always_comb begin
    wr_en  = hit_w && !iow_q && refresh_q;
    regs_d = regs_q;
    if (wr_en) begin
      regs_d[idx_w][BYTE_W-1:0] = data_q[BYTE_W-1:0];
      if (mode16 && !sbhe_q)
        regs_d[idx_w][BUS_W-1:BYTE_W] = data_q[BUS_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  // read path and chip select
  logic rd_active, rd_start, rdy_busy;

  assign rd_active  = hit_w && !ior_q;
  assign rd_start   = rd_active && ior_prev_q;
  assign rd_data_oe = rd_active;
  assign rd_data    = rd_active ? regs_q[idx_w] : '0;
  assign cs16_oe    = hit_w;
  assign cs16_o     = 1'b0;

  isa_ready_timer #(.WAIT_CYC(WAIT_CYC)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rd_start),
    .dis_i   (cfg_rdy_dis),
    .busy_o  (rdy_busy)
  );

  assign chrdy_oe = rdy_busy;
  assign chrdy_o  = 1'b0;

  // interrupt pending
  logic irq_pend_q, irq_pend_d;

  always_comb begin
    irq_pend_d = irq_pend_q;
    if (isq_rd && isq_empty) irq_pend_d = 1'b0;
    if (irq_event)           irq_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pend_q <= 1'b0;
    else        irq_pend_q <= irq_pend_d;
  end

  isa_line_router #(.N(NUM_IRQ), .SEL_W(IRQ_SEL_W)) u_irq (
    .sel_i   (cfg_irq_sel),
    .val_i   (irq_pend_q),
    .line_o  (irq_o),
    .line_oe (irq_oe)
  );

  isa_line_router #(.N(NUM_DMA), .SEL_W(DMA_SEL_W)) u_dma (
    .sel_i   (cfg_dma_sel),
    .val_i   (dma_req),
    .line_o  (dmarq_o),
    .line_oe (dmarq_oe)
  );

  always_comb begin
    dma_ack = 1'b0;
    for (int i = 0; i < NUM_DMA; i++)
      if (cfg_dma_sel == DMA_SEL_W'(i)) dma_ack = !dmack_n[i];
  end

  // R1
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(idx_w)][BYTE_W-1:0] == $past(data_q[BYTE_W-1:0])));

  // R2
  refresh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_q |=> $stable(regs_q));

  // R3
  miss_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_w |=> $stable(regs_q));

  // R4
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hi_chk
    narrow_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode16 |=> $stable(regs_q[g][BUS_W-1:BYTE_W]));
  end

  // R9
  irq_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_oe));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isq_rd && isq_empty && !irq_event) |=> (irq_o == '0));

  // R11
  dma_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dmarq_oe));
endmodule

// File: tb/tb_isa_io_slave.sv
`timescale 1ns/1ps
module tb_isa_io_slave;
  localparam int ADDR_W = 10, NUM_REGS = 4, WAIT_CYC = 2, NUM_IRQ = 4, NUM_DMA = 3;
  localparam logic [9:0] BASE = 10'h300;

  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] cfg_base_addr;
  logic cfg_rdy_dis;
  logic [1:0] cfg_irq_sel, cfg_dma_sel;
  logic soft_rst;
  logic [9:0] bus_addr;
  logic [15:0] bus_data_in;
  logic bus_iow_n, bus_ior_n, bus_refresh_n, bus_sbhe_n;
  logic [15:0] rd_data;
  logic rd_data_oe, cs16_o, cs16_oe, chrdy_o, chrdy_oe;
  logic irq_event, isq_rd, isq_empty;
  logic [3:0] irq_o, irq_oe;
  logic dma_req;
  logic [2:0] dmarq_o, dmarq_oe, dmack_n;
  logic dma_ack, mode16;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string req; logic [15:0] val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  isa_io_slave #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WAIT_CYC(WAIT_CYC),
                 .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_addr(cfg_base_addr), .cfg_rdy_dis(cfg_rdy_dis),
    .cfg_irq_sel(cfg_irq_sel), .cfg_dma_sel(cfg_dma_sel), .soft_rst(soft_rst),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in), .bus_iow_n(bus_iow_n),
    .bus_ior_n(bus_ior_n), .bus_refresh_n(bus_refresh_n), .bus_sbhe_n(bus_sbhe_n),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .cs16_o(cs16_o), .cs16_oe(cs16_oe),
    .chrdy_o(chrdy_o), .chrdy_oe(chrdy_oe), .irq_event(irq_event), .isq_rd(isq_rd),
    .isq_empty(isq_empty), .irq_o(irq_o), .irq_oe(irq_oe), .dma_req(dma_req),
    .dmarq_o(dmarq_o), .dmarq_oe(dmarq_oe), .dmack_n(dmack_n), .dma_ack(dma_ack),
    .mode16(mode16)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_write(input logic [9:0] a, input logic [15:0] d);
    bus_addr = a; bus_data_in = d; bus_iow_n = 1'b0;
    tick(2);
    bus_iow_n = 1'b1;
    tick(2);
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic io_read(input logic [9:0] a, input logic [15:0] e, input string req,
                         output int rdy_cnt);
    exp_t it;
    it.req = req; it.val = e;
    exp_q.push_back(it);
    bus_addr = a; bus_ior_n = 1'b0; rdy_cnt = 0;
    repeat (WAIT_CYC + 4) begin
      @(negedge clk);
      if (chrdy_oe) rdy_cnt++;
    end
    bus_ior_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (chrdy_oe) rdy_cnt++;
    end
  endtask

  // monitor: pops expected items as reads appear on the port
  logic oe_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_data_oe && !oe_seen) begin
        if (exp_q.size() == 0) begin
          check("R12", 32'(rd_data_oe), 32'h0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(it.req, 32'(rd_data), 32'(it.val));
        end
      end
      oe_seen = rd_data_oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int rc;
    rst_n = 1'b0; cfg_base_addr = BASE; cfg_rdy_dis = 1'b0; cfg_irq_sel = 2'd1;
    cfg_dma_sel = 2'd0; soft_rst = 1'b0; bus_addr = 10'h000; bus_data_in = '0;
    bus_iow_n = 1'b1; bus_ior_n = 1'b1; bus_refresh_n = 1'b1; bus_sbhe_n = 1'b1;
    irq_event = 1'b0; isq_rd = 1'b0; isq_empty = 1'b0; dma_req = 1'b0; dmack_n = 3'b111;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R4 reset state
    check("R4", 32'(mode16), 32'h0);
    check("R3", 32'(cs16_oe), 32'h0);
    check("R7", 32'(chrdy_oe), 32'h0);
    check("R9", 32'(irq_o), 32'h0);

    // R3 chip select at window edges
    bus_addr = 10'h302; tick(2);
    check("R3", {30'h0, cs16_oe, cs16_o}, 32'h2);
    bus_addr = 10'h308; tick(2);
    check("R3", 32'(cs16_oe), 32'h0);
    bus_addr = 10'h2FE; tick(2);
    check("R3", 32'(cs16_oe), 32'h0);

    // R1 R4 narrow write keeps high byte
    io_write(10'h302, 16'h1234);
    io_read(10'h302, 16'h0034, "R1", rc);
    check("R7", 32'(rc), 32'(WAIT_CYC));

    // R2 refresh blocks write
    bus_refresh_n = 1'b0;
    io_write(10'h302, 16'h00FF);
    bus_refresh_n = 1'b1;
    io_read(10'h302, 16'h0034, "R2", rc);

    // R3 out-of-window write ignored
    io_write(10'h308, 16'h0055);
    io_read(10'h300, 16'h0000, "R3", rc);

    // R5 fall alone keeps narrow mode
    bus_sbhe_n = 1'b0; tick(2);
    io_write(10'h304, 16'hABCD);
    check("R5", 32'(mode16), 32'h0);
    io_read(10'h304, 16'h00CD, "R4", rc);
    bus_sbhe_n = 1'b1; tick(3);
    check("R5", 32'(mode16), 32'h1);

    // R6 wide writes
    bus_sbhe_n = 1'b0;
    io_write(10'h306, 16'hBEEF);
    bus_sbhe_n = 1'b1; tick(1);
    io_read(10'h306, 16'hBEEF, "R6", rc);
    io_write(10'h306, 16'h1111);
    io_read(10'h306, 16'hBE11, "R6", rc);

    // R5 software reset
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0; tick(1);
    check("R5", 32'(mode16), 32'h0);

    // R8 ready disabled
    cfg_rdy_dis = 1'b1; tick(1);
    io_read(10'h302, 16'h0034, "R12", rc);
    check("R8", 32'(rc), 32'h0);
    cfg_rdy_dis = 1'b0;

    // R9 R10 interrupt routing and clearing
    cfg_irq_sel = 2'd2;
    irq_event = 1'b1; tick(1); irq_event = 1'b0; tick(1);
    check("R9", {24'h0, irq_oe, irq_o}, 32'h44);
    isq_rd = 1'b1; isq_empty = 1'b0; tick(1); isq_rd = 1'b0; tick(1);
    check("R10", 32'(irq_o), 32'h4);
    isq_rd = 1'b1; isq_empty = 1'b1; tick(1); isq_rd = 1'b0; isq_empty = 1'b0; tick(1);
    check("R10", {24'h0, irq_oe, irq_o}, 32'h40);
    cfg_irq_sel = 2'd0;
    irq_event = 1'b1; tick(1); irq_event = 1'b0; tick(1);
    check("R9", {24'h0, irq_oe, irq_o}, 32'h11);

    // R11 DMA routing
    cfg_dma_sel = 2'd1; dma_req = 1'b1; tick(1);
    check("R11", {26'h0, dmarq_oe, dmarq_o}, 32'h12);
    dmack_n = 3'b101; tick(1);
    check("R11", 32'(dma_ack), 32'h1);
    dmack_n = 3'b110; tick(1);
    check("R11", 32'(dma_ack), 32'h0);
    cfg_dma_sel = 2'd3; tick(1);
    check("R11", {26'h0, dmarq_oe, dmarq_o}, 32'h0);

    tick(2);
    // R12 every issued read was seen on the port
    check("R12", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule